// File: doc/BRIEF.md
# Programmable Bit-Mux LVDS Serializer

This block turns parallel pixel words into seven-bit serial streams for up to two LVDS channels. Each channel has a configurable number of data lanes (four by default) and one clock lane. Every bit slot of every data lane takes its bit from the incoming pixel through its own programmable select field. Software can therefore lay out 18-bit or 24-bit panel maps, or any other order, without changing the hardware. The analog drivers and the PLL sit outside the block. The seven-times bit rate is modelled by a bit-clock enable on a single fast clock. Each pixel occupies seven enabled clock cycles.

Two pixel sources feed the block. In dual-channel use, source A and source B carry alternate pixels. A swap flag exchanges which physical channel carries which source. Mode flags in a control register switch off the fourth data lane for 18-bit panels and switch off channel 2 entirely for single-channel panels. Serialization starts only after two things are true: software has set both the interface enable and the serializer enable, and a settle interval has passed with both still set. The source presents each new pixel after the block's pixel strobe, and the block samples it at the next load.

Top module: `lvds_bitmux_ser`

## Requirements
- R1: After reset every serial output and `pix_stb` are 0, and every register reads back as 0.
- R2: Register writes take effect on the clock edge where `reg_wr` is high, and `reg_rdata` shows the register at `reg_addr` one edge later. The register map is as follows. Address 0 is control: bit0 interface enable, bit1 single-channel, bit2 18-bit mode, bit3 channel swap, bits 7:4 channel-1 lane enables, bits 11:8 channel-2 lane enables, bit12 channel-1 clock enable, bit13 channel-2 clock enable. Address 1 bit0 is the serializer enable. Address 2+2L holds the selects for slots 0..3 of lane L, and address 3+2L holds the selects for slots 4..6 of lane L. Each select is 5 bits wide and sits at bit 8*j of its register. Unimplemented bits and addresses read 0.
- R3: Both channels use the same per-lane select fields. The output bit for slot k of lane L equals bit S of the pixel {DE,VS,HS,B[7:0],G[7:0],R[7:0]}, where R[0] is bit 0 and DE is bit 26, and S is that lane's slot-k select. A select of 27 or more yields 0.
- R4: Slot 6 goes out first and slot 0 last. `pix_stb` is high for one cycle at the point where slot 6 first appears on the outputs. The pixel that is being sent is the one present on the pixel inputs at the load edge that raised `pix_stb`.
- R5: An enabled clock lane sends 1,1,0,0,0,1,1 for every pixel, in step with the data lanes.
- R6: A data lane whose enable bit is 0 sends all zeros, and so does a clock lane whose enable bit is 0.
- R7: With 18-bit mode set, data lane 3 of both channels sends zeros whatever its enable bit says.
- R8: With single-channel set, all channel-2 data lanes and the channel-2 clock lane send zeros.
- R9: With swap clear, physical channel 1 carries source A and channel 2 carries source B. With swap set, the two sources are exchanged.
- R10: Outputs stay 0 until both enable bits have been 1 for 16 consecutive cycles. With `bit_en` held high, the first `pix_stb` appears 17 edges after the write that completes the pair. Clearing either enable forces all outputs to 0 from the second edge after the write.
- R11: The outputs advance only on cycles with `bit_en` high. On other cycles they hold and `pix_stb` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit-clock enable; one serial bit per enabled cycle |
| pix_a | input | 27 | Pixel source A {DE,VS,HS,B,G,R} |
| pix_b | input | 27 | Pixel source B {DE,VS,HS,B,G,R} |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for reg_addr |
| ser_data | output | 8 | Serial data lanes, index channel*4+lane |
| ser_clk | output | 2 | Serial clock lanes, one per channel |
| pix_stb | output | 1 | One-cycle pulse when a new pixel starts on the outputs |

## Verification
Some properties are checked on every cycle. With the enables not both set, the outputs must be silent on the next cycle. Without `bit_en`, the outputs must hold. Right after each load, an enabled clock lane must lead with a 1. Right after each load in 18-bit or single-channel mode, the lanes those modes remove must be silent. Other behaviour only the scenarios can show. That covers the per-slot routing under a sweep of every select value, the slot order and the pixel sampling point, the swap and enable combinations, the exact length of the settle interval, and register readback.

// File: rtl/lvds_bm_pkg.sv
package lvds_bm_pkg;

  // Physical channel count of the link.
  localparam int CHANS = 2;

  // Mode flags, packed to match control register bits [3:0].
  typedef struct packed {
    logic swap;
    logic rgb18;
    logic single;
    logic intf_en;
  } mode_t;

endpackage

// File: rtl/lvds_bm_regs.sv
module lvds_bm_regs
  import lvds_bm_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int SLOTS  = 7,
  parameter int SEL_W  = 5,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DATA_W-1:0]            wdata,
  output logic [DATA_W-1:0]            rdata,
  output mode_t                        mode,
  output logic [CHANS*LANES-1:0]       lane_en,
  output logic [CHANS-1:0]             clk_en,
  output logic                         ser_en,
  output logic [LANES*SLOTS*SEL_W-1:0] sel_flat
);

  localparam int SLOTS_LO = 4;
  localparam int SLOTS_HI = SLOTS - SLOTS_LO;
  localparam int FLD      = 8;
  localparam int MODE_W   = 4;
  localparam int CTRL_W   = MODE_W + CHANS*LANES + CHANS;
  localparam int A_CTRL   = 0;
  localparam int A_SER    = 1;
  localparam int A_SEL0   = 2;
  localparam int NSEL     = LANES*SLOTS;

  logic [CTRL_W-1:0] ctrl_q;
  logic              ser_q;
  logic [SEL_W-1:0]  sel_q [NSEL];
  logic [DATA_W-1:0] rd_mux;
  logic              unused_wbits;

  assign unused_wbits = ^wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      ser_q  <= 1'b0;
      for (int i = 0; i < NSEL; i++) sel_q[i] <= '0;
    end else if (wr) begin
      if (addr == ADDR_W'(A_CTRL)) ctrl_q <= wdata[CTRL_W-1:0];
      if (addr == ADDR_W'(A_SER))  ser_q  <= wdata[0];
      for (int l = 0; l < LANES; l++) begin
        if (addr == ADDR_W'(A_SEL0 + 2*l)) begin
          for (int j = 0; j < SLOTS_LO; j++)
            sel_q[l*SLOTS + j] <= wdata[j*FLD +: SEL_W];
        end
        if (addr == ADDR_W'(A_SEL0 + 2*l + 1)) begin
          for (int j = 0; j < SLOTS_HI; j++)
            sel_q[l*SLOTS + SLOTS_LO + j] <= wdata[j*FLD +: SEL_W];
        end
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr == ADDR_W'(A_CTRL)) rd_mux[CTRL_W-1:0] = ctrl_q;
    if (addr == ADDR_W'(A_SER))  rd_mux[0] = ser_q;
    for (int l = 0; l < LANES; l++) begin
      if (addr == ADDR_W'(A_SEL0 + 2*l)) begin
        for (int j = 0; j < SLOTS_LO; j++)
          rd_mux[j*FLD +: SEL_W] = sel_q[l*SLOTS + j];
      end
      if (addr == ADDR_W'(A_SEL0 + 2*l + 1)) begin
        for (int j = 0; j < SLOTS_HI; j++)
          rd_mux[j*FLD +: SEL_W] = sel_q[l*SLOTS + SLOTS_LO + j];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end

  assign mode    = mode_t'(ctrl_q[MODE_W-1:0]);
  assign lane_en = ctrl_q[MODE_W +: CHANS*LANES];
  assign clk_en  = ctrl_q[MODE_W + CHANS*LANES +: CHANS];
  assign ser_en  = ser_q;

  for (genvar i = 0; i < NSEL; i++) begin : g_sel_out
    assign sel_flat[i*SEL_W +: SEL_W] = sel_q[i];
  end

endmodule

// File: rtl/lvds_bm_mux.sv
module lvds_bm_mux #(
  parameter int SLOTS = 7,
  parameter int SEL_W = 5
) (
  input  logic [(1<<SEL_W)-1:0] src,
  input  logic [SLOTS*SEL_W-1:0] sel,
  output logic [SLOTS-1:0]       word
);

  // One full-width selector per bit slot of the lane.
  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    assign word[k] = src[sel[k*SEL_W +: SEL_W]];
  end

endmodule

// File: rtl/lvds_bm_shift.sv
module lvds_bm_shift #(
  parameter int SLOTS = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             load,
  input  logic             adv,
  input  logic             en,
  input  logic [SLOTS-1:0] din,
  output logic             q
);

  logic [SLOTS-1:0] sh;

  // The highest slot leaves first; a load replaces a shift.
  always_ff @(posedge clk) begin
    if (rst || clr)  sh <= '0;
    else if (load)   sh <= en ? din : '0;
    else if (adv)    sh <= {sh[SLOTS-2:0], 1'b0};
  end

  assign q = sh[SLOTS-1];

endmodule

// File: rtl/lvds_bitmux_ser.sv
module lvds_bitmux_ser
  import lvds_bm_pkg::*;
#(
  parameter int               LANES      = 4,
  parameter int               SLOTS      = 7,
  parameter int               SEL_W      = 5,
  parameter int               PIX_W      = 27,
  parameter int               ADDR_W     = 4,
  parameter int               DATA_W     = 32,
  parameter int               SETTLE_CYC = 16,
  parameter logic [SLOTS-1:0] CLK_PAT    = 7'b1100011
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bit_en,
  input  logic [PIX_W-1:0]       pix_a,
  input  logic [PIX_W-1:0]       pix_b,
  input  logic                   reg_wr,
  input  logic [ADDR_W-1:0]      reg_addr,
  input  logic [DATA_W-1:0]      reg_wdata,
  output logic [DATA_W-1:0]      reg_rdata,
  output logic [CHANS*LANES-1:0] ser_data,
  output logic [CHANS-1:0]       ser_clk,
  output logic                   pix_stb
);

  localparam int NCH   = CHANS;
  localparam int SRC_W = 1 << SEL_W;
  localparam int CNT_W = $clog2(SLOTS);
  localparam int ST_W  = $clog2(SETTLE_CYC + 1);
  localparam int LSEL  = SLOTS*SEL_W;

  mode_t                   mode;
  logic [NCH*LANES-1:0]    lane_en;
  logic [NCH-1:0]          clk_en;
  logic                    ser_en;
  logic [LANES*LSEL-1:0]   sel_flat;
  logic                    md_single;
  logic                    md_rgb18;

  lvds_bm_regs #(
    .LANES(LANES), .SLOTS(SLOTS), .SEL_W(SEL_W),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .mode(mode), .lane_en(lane_en), .clk_en(clk_en),
    .ser_en(ser_en), .sel_flat(sel_flat)
  );

  assign md_single = mode.single;
  assign md_rgb18  = mode.rgb18;

  // Activation: both enables, then a settle interval.
  logic            go;
  logic            active;
  logic            run;
  logic [ST_W-1:0] scnt;

  assign go  = ser_en & mode.intf_en;
  assign run = active & go;

  always_ff @(posedge clk) begin
    if (rst || !go) begin
      scnt   <= '0;
      active <= 1'b0;
    end else if (!active) begin
      if (scnt == ST_W'(SETTLE_CYC - 1)) active <= 1'b1;
      else                               scnt   <= scnt + 1'b1;
    end
  end

  // Slot counter, pixel load and strobe.
  logic [CNT_W-1:0] cnt;
  logic             load_px;
  logic             adv;

  assign adv     = run & bit_en;
  assign load_px = adv & (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt <= '0;
    else if (bit_en)  cnt <= (cnt == CNT_W'(SLOTS - 1)) ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) pix_stb <= 1'b0;
    else     pix_stb <= load_px;
  end

  // Pixel sources widened to the select range; spare bits read 0.
  logic [SRC_W-1:0] src [NCH];
  assign src[0] = SRC_W'(pix_a);
  assign src[1] = SRC_W'(pix_b);

  logic [NCH-1:0] clk_on;

  for (genvar p = 0; p < NCH; p++) begin : g_ch
    logic [SRC_W-1:0] csrc;
    logic             ch_kill;

    assign csrc = mode.swap ? src[NCH-1-p] : src[p];

    if (p == 0) begin : g_k0
      assign ch_kill = 1'b0;
    end else begin : g_k1
      assign ch_kill = md_single;
    end

    assign clk_on[p] = clk_en[p] & ~ch_kill;

    lvds_bm_shift #(.SLOTS(SLOTS)) u_clk_lane (
      .clk(clk), .rst(rst), .clr(~run), .load(load_px), .adv(adv),
      .en(clk_on[p]), .din(CLK_PAT), .q(ser_clk[p])
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [SLOTS-1:0] word;
      logic             on;

      lvds_bm_mux #(.SLOTS(SLOTS), .SEL_W(SEL_W)) u_mux (
        .src(csrc), .sel(sel_flat[l*LSEL +: LSEL]), .word(word)
      );

      if (l == LANES - 1) begin : g_top
        assign on = lane_en[p*LANES + l] & ~ch_kill & ~md_rgb18;
      end else begin : g_low
        assign on = lane_en[p*LANES + l] & ~ch_kill;
      end

      lvds_bm_shift #(.SLOTS(SLOTS)) u_lane (
        .clk(clk), .rst(rst), .clr(~run), .load(load_px), .adv(adv),
        .en(on), .din(word), .q(ser_data[p*LANES + l])
      );
    end
  end

endmodule

// File: rtl/lvds_bitmux_ser_chk.sv
module lvds_bitmux_ser_chk #(
  parameter int LANES = 4,
  parameter int CHANS = 2
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   bit_en,
  input logic                   go,
  input logic                   run,
  input logic                   load,
  input logic                   single,
  input logic                   rgb18,
  input logic [CHANS-1:0]       clk_on,
  input logic [CHANS*LANES-1:0] ser_data,
  input logic [CHANS-1:0]       ser_clk,
  input logic                   pix_stb
);

  // R10: without both enables the link is silent next cycle.
  p_quiet_off_r10: assert property (@(posedge clk) disable iff (rst)
    !go |=> (ser_data == '0 && ser_clk == '0 && !pix_stb));

  // R11: no bit enable, no movement.
  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (run && !bit_en) |=> ($stable(ser_data) && $stable(ser_clk) && !pix_stb));

  // R5: an enabled clock lane leads each pixel with a 1.
  p_clk_lead_r5: assert property (@(posedge clk) disable iff (rst)
    load |=> (ser_clk == $past(clk_on)));

  // R7: 18-bit mode silences the top data lane of both channels.
  p_rgb18_off_r7: assert property (@(posedge clk) disable iff (rst)
    (load && rgb18) |=> (ser_data[LANES-1] == 1'b0 && ser_data[2*LANES-1] == 1'b0));

  // R8: single-channel mode silences channel 2.
  p_single_off_r8: assert property (@(posedge clk) disable iff (rst)
    (load && single) |=> (ser_data[2*LANES-1:LANES] == '0 && ser_clk[1] == 1'b0));

  // R4: pixel strobes are never back to back.
  p_stb_gap_r4: assert property (@(posedge clk) disable iff (rst)
    pix_stb |=> !pix_stb);

endmodule

bind lvds_bitmux_ser lvds_bitmux_ser_chk #(.LANES(LANES), .CHANS(NCH)) u_chk (
  .clk(clk), .rst(rst), .bit_en(bit_en), .go(go), .run(run), .load(load_px),
  .single(md_single), .rgb18(md_rgb18), .clk_on(clk_on),
  .ser_data(ser_data), .ser_clk(ser_clk), .pix_stb(pix_stb)
);

// File: tb/lvds_bitmux_ser_tb.sv
module lvds_bitmux_ser_tb;

  localparam int LANES  = 4;
  localparam int SLOTS  = 7;
  localparam int PIX_W  = 27;
  localparam int SETTLE = 16;
  localparam int NOUT   = 2*LANES;

  logic              clk = 1'b0;
  logic              rst;
  logic              bit_en;
  logic [PIX_W-1:0]  pix_a, pix_b;
  logic              reg_wr;
  logic [3:0]        reg_addr;
  logic [31:0]       reg_wdata;
  logic [31:0]       reg_rdata;
  logic [NOUT-1:0]   ser_data;
  logic [1:0]        ser_clk;
  logic              pix_stb;

  lvds_bitmux_ser u_dut (
    .clk(clk), .rst(rst), .bit_en(bit_en), .pix_a(pix_a), .pix_b(pix_b),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ser_data(ser_data), .ser_clk(ser_clk),
    .pix_stb(pix_stb)
  );

  always #10 clk = ~clk;

  int          checks = 0;
  int          fails  = 0;
  bit          done   = 1'b0;
  int          cyc    = 0;
  int          gap    = 0;
  bit          en_last;
  logic [31:0] seed   = 32'h1234_5678;
  logic [31:0] m_ctrl;
  logic [4:0]  m_sel [LANES][SLOTS];
  logic [31:0] rv;

  localparam logic [31:0] FULL = 32'h1 | (32'hFF << 4) | (32'h3 << 12);

  task automatic chk(bit ok, string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic step();
    en_last = (gap == 0) || (cyc % 3 == 0);
    bit_en  = en_last;
    @(negedge clk);
    cyc++;
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] v);
    reg_addr = a;
    step();
    v = reg_rdata;
  endtask

  function automatic logic [PIX_W-1:0] next_pix();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[31:5];
  endfunction

  task automatic write_sels();
    for (int l = 0; l < LANES; l++) begin
      logic [31:0] lo, hi;
      lo = '0; hi = '0;
      for (int j = 0; j < 4; j++) lo[j*8 +: 5] = m_sel[l][j];
      for (int j = 0; j < 3; j++) hi[j*8 +: 5] = m_sel[l][4+j];
      wr(4'(2 + 2*l), lo);
      wr(4'(3 + 2*l), hi);
    end
  endtask

  task automatic start();
    wr(4'd0, m_ctrl);
    write_sels();
    wr(4'd1, 32'd1);
  endtask

  // R10: cleared enable silences every output by the second edge.
  task automatic stop();
    wr(4'd1, 32'd0);
    step();
    chk(ser_data == '0 && ser_clk == '0 && !pix_stb, "R10 stop",
        {ser_data, ser_clk, pix_stb}, 32'd0);
  endtask

  function automatic logic [6:0] exp_word(int p, int l, logic [PIX_W-1:0] ea,
                                          logic [PIX_W-1:0] eb);
    logic [PIX_W-1:0] px;
    bit               on;
    logic [6:0]       w;
    px = ((p ^ int'(m_ctrl[3])) != 0) ? eb : ea;
    on = m_ctrl[4 + p*LANES + l] && !(p == 1 && m_ctrl[1]) &&
         !(l == LANES-1 && m_ctrl[2]);
    for (int k = 0; k < SLOTS; k++)
      w[k] = (on && m_sel[l][k] < PIX_W) ? px[m_sel[l][k]] : 1'b0;
    return w;
  endfunction

  function automatic logic [6:0] exp_clk(int p);
    bit on;
    on = m_ctrl[12 + p] && !(p == 1 && m_ctrl[1]);
    return on ? 7'b1100011 : 7'b0;
  endfunction

  task automatic run_frames(int n, string req);
    for (int f = 0; f < n; f++) begin
      int               t;
      int               k;
      logic [6:0]       gd [NOUT];
      logic [6:0]       gc [2];
      logic [PIX_W-1:0] ea, eb;
      t = 0;
      while (!pix_stb && t < 300) begin step(); t++; end
      if (!pix_stb) begin
        chk(1'b0, {req, " R4 no strobe"}, 32'd0, 32'd1);
        return;
      end
      ea = pix_a; eb = pix_b;
      pix_a = next_pix(); pix_b = next_pix();
      for (int o = 0; o < NOUT; o++) gd[o][6] = ser_data[o];
      for (int c = 0; c < 2; c++) gc[c][6] = ser_clk[c];
      k = 5;
      while (k >= 0) begin
        step();
        if (en_last) begin
          for (int o = 0; o < NOUT; o++) gd[o][k] = ser_data[o];
          for (int c = 0; c < 2; c++) gc[c][k] = ser_clk[c];
          k--;
        end
      end
      for (int p = 0; p < 2; p++) begin
        for (int l = 0; l < LANES; l++) begin
          logic [6:0] e;
          e = exp_word(p, l, ea, eb);
          chk(gd[p*LANES+l] == e, req, 32'(gd[p*LANES+l]), 32'(e));
        end
        chk(gc[p] == exp_clk(p), "R5 clock lane", 32'(gc[p]), 32'(exp_clk(p)));
      end
      if (f < n-1) step();
    end
  endtask

  task automatic lin_sel();
    for (int l = 0; l < LANES; l++)
      for (int k = 0; k < SLOTS; k++) m_sel[l][k] = 5'(7*l + k);
  endtask

  initial begin
    bit quiet;
    rst = 1'b1; bit_en = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    pix_a = 27'h5A5_A5A5; pix_b = 27'h3C3_C3C3;
    repeat (5) step();
    rst = 1'b0;
    step();

    // R1 reset state
    chk(ser_data == '0 && ser_clk == '0 && !pix_stb, "R1 outputs",
        {ser_data, ser_clk, pix_stb}, 32'd0);
    rd(4'd0, rv); chk(rv == 0, "R1 ctrl", rv, 0);
    rd(4'd1, rv); chk(rv == 0, "R1 ser", rv, 0);
    rd(4'd2, rv); chk(rv == 0, "R1 sel", rv, 0);

    // R2 register map
    wr(4'd0, 32'hFFFF_FFFF); rd(4'd0, rv); chk(rv == 32'h3FFF, "R2 ctrl", rv, 32'h3FFF);
    wr(4'd0, 32'd0);
    wr(4'd4, 32'hFFFF_FFFF); rd(4'd4, rv); chk(rv == 32'h1F1F_1F1F, "R2 sel lo", rv, 32'h1F1F_1F1F);
    wr(4'd5, 32'hFFFF_FFFF); rd(4'd5, rv); chk(rv == 32'h001F_1F1F, "R2 sel hi", rv, 32'h001F_1F1F);
    wr(4'd9, 32'h0A0B_0C0D); rd(4'd9, rv); chk(rv == 32'h000B_0C0D, "R2 lane3 hi", rv, 32'h000B_0C0D);
    wr(4'd1, 32'hFFFF_FFFF); rd(4'd1, rv); chk(rv == 32'h1, "R2 ser", rv, 1);
    wr(4'd1, 32'd0);
    rd(4'd15, rv); chk(rv == 0, "R2 unmapped", rv, 0);

    // R10 settle timing
    m_ctrl = FULL; lin_sel();
    wr(4'd0, m_ctrl); write_sels(); wr(4'd1, 32'd1);
    quiet = 1'b1;
    for (int i = 0; i < SETTLE; i++) begin
      step();
      if (ser_data != '0 || ser_clk != '0 || pix_stb) quiet = 1'b0;
    end
    chk(quiet, "R10 silent during settle", 32'(quiet), 1);
    step();
    chk(pix_stb == 1'b1, "R10 first strobe", 32'(pix_stb), 1);
    run_frames(3, "R3 R4 linear map");
    stop();

    // R10 interface enable clear keeps the link silent
    wr(4'd0, FULL & ~32'h1); wr(4'd1, 32'd1);
    quiet = 1'b1;
    for (int i = 0; i < 3*SETTLE; i++) begin
      step();
      if (ser_data != '0 || ser_clk != '0 || pix_stb) quiet = 1'b0;
    end
    chk(quiet, "R10 no interface enable", 32'(quiet), 1);
    wr(4'd1, 32'd0);

    // R3 sweep of every select value on every slot position
    m_ctrl = FULL;
    for (int s = 0; s < 32; s++) begin
      for (int l = 0; l < LANES; l++)
        for (int k = 0; k < SLOTS; k++) m_sel[l][k] = 5'((s + 7*l + k) % 32);
      start();
      run_frames(2, "R3 sweep");
      stop();
    end

    // R3 24-bit style map on lanes 0 and 3
    m_sel[0] = '{5'h08, 5'h05, 5'h04, 5'h03, 5'h02, 5'h01, 5'h00};
    m_sel[3] = '{5'h1B, 5'h17, 5'h16, 5'h0F, 5'h0E, 5'h07, 5'h06};
    start(); run_frames(2, "R3 panel map"); stop();

    // R6 lane enables
    lin_sel();
    m_ctrl = 32'h1 | (32'h5 << 4) | (32'hA << 8) | (32'h1 << 12);
    start(); run_frames(2, "R6 enables A"); stop();
    m_ctrl = 32'h1 | (32'hE << 4) | (32'h1 << 8) | (32'h2 << 12);
    start(); run_frames(2, "R6 enables B"); stop();

    // R7 18-bit mode
    m_ctrl = FULL | 32'h4;
    start(); run_frames(2, "R7 rgb18"); stop();

    // R8 single channel
    m_ctrl = FULL | 32'h2;
    start(); run_frames(2, "R8 single"); stop();

    // R9 swap, alone and with single channel
    m_ctrl = FULL | 32'h8;
    start(); run_frames(2, "R9 swap"); stop();
    m_ctrl = FULL | 32'hA;
    start(); run_frames(2, "R9 swap single"); stop();

    // R11 sparse bit enable
    gap = 1;
    m_ctrl = FULL;
    for (int l = 0; l < LANES; l++)
      for (int k = 0; k < SLOTS; k++) m_sel[l][k] = 5'((3*l + 5*k + 1) % 27);
    start(); run_frames(3, "R11 sparse bit enable"); stop();
    gap = 0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog got=%0d exp=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule